// File: doc/BRIEF.md
# Phase-Frequency Detector with Programmable Anti-Backlash Overlap

This block is a synchronous model of the phase-frequency detector in a PLL. A single fast sampling clock oversamples the divided reference stream (`ref_in`) and the divided feedback stream (`fb_in`). A rising edge on the reference sets the `up` request and a rising edge on the feedback sets the `dn` request. The leading request therefore stays high for as long as the phase or frequency error lasts.

When both requests are high, a clear is armed. It takes effect only after a selectable number of sampling cycles. This makes `up` and `dn` overlap for a guaranteed minimum width, which removes the dead zone around zero phase error. In lock, both outputs appear as short pulses of equal width.

A derived two-bit signed output gives the net pump command. A synchronous power-down input forces the detector quiet.

Top module: `pfd_abp`

## Requirements
- R1: While `rst_n` is low at a clock edge, `up` and `dn` are low after that edge and `net_o` is 2'b00.
- R2: If an input goes from 0 to 1 before clock edge k, its request rises after edge k+2 (`ref_in` raises `up`, `fb_in` raises `dn`). This assumes the request was low and power-down is not asserted.
- R3: If one input rises d sampling cycles before the other, the leading request stays high for d+W cycles and the lagging one for W cycles, where W is the overlap width.
- R4: `abp_sel` sets the overlap width W: code 2'b00 gives 2 cycles, 2'b01 gives 1, 2'b10 gives 4 and 2'b11 gives 2. When both inputs rise together, `up` and `dn` are each high for exactly W cycles.
- R5: After an overlap with no pending edge and no power-down, `up` and `dn` return low on the same clock edge.
- R6: A further rising edge on an input whose request is already high, while the other request is low, has no effect. The request width still follows R3, measured from the first edge.
- R7: A rising edge on either input that is detected while both requests are high is held and re-asserts that request on the edge that ends the overlap, so that no edge is lost.
- R8: `net_o` is 2'b01 (+1) when only `up` is high, 2'b11 (−1) when only `dn` is high, and 2'b00 otherwise.
- R9: While `pwr_dn` is high at a clock edge, both requests are low after that edge and input edges are ignored. An input already high when `pwr_dn` falls does not set its request until it makes a new rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn | input | 1 | Synchronous power-down: clears and holds both requests low |
| abp_sel | input | 2 | Overlap-width select code |
| ref_in | input | 1 | Divided reference stream (asynchronous) |
| fb_in | input | 1 | Divided feedback stream (asynchronous) |
| up | output | 1 | Pump-up request |
| dn | output | 1 | Pump-down request |
| net_o | output | 2 | Signed net pump command (+1, −1, 0) |

## Verification
An input change made before clock edge k reaches its request output after edge k+2. That is two synchronizer flops plus the request flop. Clears and power-down take effect after the edge on which they are decided, and `net_o` follows the requests in the same cycle.

The bench drives inputs and samples outputs on the falling edge. Every stimulus starts at cycle index 0 of a 40-cycle window, and the first-high index, last-high index and high count of each request are recorded. The bench then compares these against the offset plus three cycles and against d+W or W. Idle gaps with both inputs low separate the windows, so each measurement starts from cleared requests.

// File: rtl/pfd_pkg.sv
// Package: shared types for the phase-frequency detector.
// Assumes: net command is a 2-bit two's complement value.
package pfd_pkg;

    // Net pump command encodings
    typedef enum logic [1:0] {
        NET_ZERO = 2'b00,
        NET_PUMP_UP = 2'b01,
        NET_PUMP_DN = 2'b11
    } net_cmd_t;

    // Number of detector channels (reference and feedback)
    localparam int NUM_CH = 2;
    localparam int CH_REF = 0;
    localparam int CH_FB = 1;

endpackage

// File: rtl/pfd_edge_sync.sv
// Module: pfd_edge_sync
// Brings an asynchronous divided clock into the sampling domain through a
// chain of SYNC_STAGES flops and emits a one-cycle pulse on each 0-to-1
// transition seen at the chain output.
// Assumes: the input stays stable for at least one sampling period per level.
module pfd_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the input through the synchronizer plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], async_i};
        end
    end

    // Rising edge: newest synchronized sample is 1, previous one is 0
    always_comb begin
        rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    end

    // R2
    edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pfd_flag.sv
// Module: pfd_flag
// One request flag of the detector, with data tied high. A detected edge sets
// it, and the shared clear drops it. An edge that arrives while both flags
// are high is remembered and re-sets the flag on the clearing edge.
// Assumes: clear_i is only asserted while both flags are high.
module pfd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_dn,
    input  logic edge_i,
    input  logic both_i,
    input  logic clear_i,
    output logic q_o
);

    logic q_q;
    logic pend_q;

    // Set on edge, clear on overlap end, re-latch any held edge
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn) begin
            q_q    <= 1'b0;
            pend_q <= 1'b0;
        end else if (clear_i) begin
            q_q    <= edge_i | pend_q;
            pend_q <= 1'b0;
        end else begin
            q_q    <= q_q | edge_i;
            pend_q <= pend_q | (edge_i & both_i);
        end
    end

    assign q_o = q_q;

    // R9
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !q_o);

endmodule

// File: rtl/pfd_abp_timer.sv
// Module: pfd_abp_timer
// Counts the cycles during which both requests are high and raises the clear
// when the overlap selected by sel_i has elapsed.
// Assumes: every overlap width parameter is at least 1.
module pfd_abp_timer #(
    parameter int OVL_C0 = 2,
    parameter int OVL_C1 = 1,
    parameter int OVL_C2 = 4,
    parameter int OVL_C3 = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_dn,
    input  logic [1:0] sel_i,
    input  logic       both_i,
    output logic       clear_o
);

    localparam int MAX_A = (OVL_C0 > OVL_C1) ? OVL_C0 : OVL_C1;
    localparam int MAX_B = (OVL_C2 > OVL_C3) ? OVL_C2 : OVL_C3;
    localparam int WMAX  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = (WMAX <= 2) ? 1 : $clog2(WMAX);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    // Translate the select code into the final count of the overlap
    always_comb begin
        unique case (sel_i)
            2'b00:   last_cnt = CNT_W'(OVL_C0 - 1);
            2'b01:   last_cnt = CNT_W'(OVL_C1 - 1);
            2'b10:   last_cnt = CNT_W'(OVL_C2 - 1);
            default: last_cnt = CNT_W'(OVL_C3 - 1);
        endcase
    end

    // Clear when the overlap count reaches (or passed) the selected end
    always_comb begin
        clear_o = both_i && !pwr_dn && (cnt_q >= last_cnt);
    end

    // Count overlap cycles, restarting whenever the overlap ends
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn || !both_i || clear_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    overlap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(both_i) |-> (cnt_q == '0));

endmodule

// File: rtl/pfd_abp.sv
// Module: pfd_abp (top)
// Oversampled phase-frequency detector. The reference edge sets up and the
// feedback edge sets dn. Once both are set, a programmable overlap timer
// clears them together, so short equal pulses appear in lock.
// Assumes: ref_in and fb_in are asynchronous divided clocks much slower
// than clk.
module pfd_abp #(
    parameter int SYNC_STAGES = 2,
    parameter int OVL_C0 = 2,
    parameter int OVL_C1 = 1,
    parameter int OVL_C2 = 4,
    parameter int OVL_C3 = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_dn,
    input  logic [1:0] abp_sel,
    input  logic       ref_in,
    input  logic       fb_in,
    output logic       up,
    output logic       dn,
    output logic [1:0] net_o
);

    import pfd_pkg::*;

    logic [NUM_CH-1:0] raw_in;
    logic [NUM_CH-1:0] rise;
    logic [NUM_CH-1:0] flag_q;
    logic              both;
    logic              clear;
    net_cmd_t          net_cmd;

    assign raw_in[CH_REF] = ref_in;
    assign raw_in[CH_FB]  = fb_in;

    // One synchronizer and one request flag per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pfd_edge_sync #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .async_i(raw_in[ch]),
            .rise_o (rise[ch])
        );

        pfd_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .pwr_dn (pwr_dn),
            .edge_i (rise[ch]),
            .both_i (both),
            .clear_i(clear),
            .q_o    (flag_q[ch])
        );
    end

    // Overlap detection feeding the delayed clear
    assign both = flag_q[CH_REF] & flag_q[CH_FB];

    pfd_abp_timer #(
        .OVL_C0(OVL_C0),
        .OVL_C1(OVL_C1),
        .OVL_C2(OVL_C2),
        .OVL_C3(OVL_C3)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_dn (pwr_dn),
        .sel_i  (abp_sel),
        .both_i (both),
        .clear_o(clear)
    );

    // Net pump command from the two requests
    always_comb begin
        unique case (flag_q)
            2'b01:   net_cmd = NET_PUMP_UP;
            2'b10:   net_cmd = NET_PUMP_DN;
            default: net_cmd = NET_ZERO;
        endcase
    end

    assign up    = flag_q[CH_REF];
    assign dn    = flag_q[CH_FB];
    assign net_o = net_cmd;

    // R5
    up_fall_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(up) && !$past(pwr_dn)) |-> $past(dn));

    // R5
    dn_fall_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dn) && !$past(pwr_dn)) |-> $past(up));

endmodule

// File: tb/pfd_abp_tb.sv
// Bench for pfd_abp: table-driven offset/width vectors, then directed tests.
module pfd_abp_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_dn = 1'b0;
    logic [1:0] abp_sel = 2'b00;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic       up;
    logic       dn;
    logic [1:0] net_o;

    int n_vec = 0;
    int n_bad = 0;
    int cu, cd, cp, cn, fu, fd, lu, ld;

    always #4 clk = ~clk;

    pfd_abp u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_dn (pwr_dn),
        .abp_sel(abp_sel),
        .ref_in (ref_in),
        .fb_in  (fb_in),
        .up     (up),
        .dn     (dn),
        .net_o  (net_o)
    );

    typedef struct packed {
        logic [1:0] sel;
        logic       ref_lead;
        logic [3:0] d;
        logic [5:0] exp_up;
        logic [5:0] exp_dn;
    } vec_t;

    // Expected widths: leader d+W, lagger W (R3, R4)
    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 1'b1, 4'd3, 6'd5, 6'd2},
        '{2'b01, 1'b0, 4'd5, 6'd1, 6'd6},
        '{2'b10, 1'b1, 4'd0, 6'd4, 6'd4},
        '{2'b11, 1'b1, 4'd7, 6'd9, 6'd2},
        '{2'b00, 1'b1, 4'd0, 6'd2, 6'd2},
        '{2'b01, 1'b1, 4'd0, 6'd1, 6'd1},
        '{2'b10, 1'b0, 4'd2, 6'd4, 6'd6},
        '{2'b11, 1'b0, 4'd1, 6'd2, 6'd3}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_meas();
        cu = 0; cd = 0; cp = 0; cn = 0;
        fu = -1; fd = -1; lu = -1; ld = -1;
    endtask

    // Drive inputs on the falling edge, then sample outputs
    task automatic step(input int i, input logic r, input logic f, input logic p);
        @(negedge clk);
        ref_in = r;
        fb_in  = f;
        pwr_dn = p;
        if (up) begin cu++; lu = i; if (fu < 0) fu = i; end
        if (dn) begin cd++; ld = i; if (fd < 0) fd = i; end
        if (net_o == 2'b01) cp++;
        if (net_o == 2'b11) cn++;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            ref_in = 1'b0;
            fb_in  = 1'b0;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 up after reset", int'(up), 0);
        check("R1 dn after reset", int'(dn), 0);
        check("R1 net after reset", int'(net_o), 0);

        // Table of offset / overlap vectors
        for (int v = 0; v < NV; v++) begin
            automatic vec_t t = VEC[v];
            automatic int tr = t.ref_lead ? 0 : int'(t.d);
            automatic int tf = t.ref_lead ? int'(t.d) : 0;
            automatic int eu = int'(t.exp_up);
            automatic int ed = int'(t.exp_dn);
            abp_sel = t.sel;
            idle(4);
            clr_meas();
            for (int i = 0; i < 40; i++) step(i, i >= tr, i >= tf, 1'b0);
            check("R2 up rise cycle", fu, tr + 3);
            check("R2 dn rise cycle", fd, tf + 3);
            check("R3 R4 up width", cu, eu);
            check("R3 R4 dn width", cd, ed);
            check("R5 common fall", lu, ld);
            check("R8 net +1 cycles", cp, (eu > ed) ? eu - ed : 0);
            check("R8 net -1 cycles", cn, (ed > eu) ? ed - eu : 0);
            idle(8);
        end

        // R6: second reference edge before feedback arrives is ignored (W=1)
        abp_sel = 2'b01;
        idle(4);
        clr_meas();
        for (int i = 0; i < 40; i++) step(i, (i < 3) || (i >= 6), i >= 20, 1'b0);
        check("R6 up width", cu, 21);
        check("R6 dn width", cd, 1);
        check("R6 common fall", lu, ld);
        idle(8);

        // R7: reference edge during overlap is re-latched (W=4)
        abp_sel = 2'b10;
        idle(4);
        clr_meas();
        for (int i = 0; i < 40; i++) step(i, i != 1, (i < 8) || (i >= 14), 1'b0);
        check("R7 up held across clear", cu, 18);
        check("R7 up last cycle", lu, 20);
        check("R7 dn two overlaps", cd, 8);
        idle(8);

        // R9: edges ignored while powered down
        abp_sel = 2'b00;
        clr_meas();
        for (int i = 0; i < 20; i++) step(i, 1'b1, i >= 2, 1'b1);
        check("R9 up while powered down", cu, 0);
        check("R9 dn while powered down", cd, 0);
        idle(6);
        pwr_dn = 1'b0;
        idle(4);

        // R9: power-down mid-request, no re-set from a level, new edge works
        clr_meas();
        for (int i = 0; i < 30; i++) step(i, 1'b1, i >= 20, (i >= 8) && (i < 16));
        check("R9 up cleared by power-down", cu, 6);
        check("R9 up last cycle", lu, 8);
        check("R9 dn after new edge", cd, 7);
        check("R8 net +1 during lone up", cp, 6);
        check("R8 net -1 during lone dn", cn, 7);
        pwr_dn = 1'b1;
        idle(4);
        pwr_dn = 1'b0;
        idle(4);
        check("R9 dn cleared", int'(dn), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule